// File: doc/BRIEF.md
# Oscillator Grid Enable Sweep Generator

This block drives the single enable line of a large ring-oscillator grid so that the grid loads the supply in a controlled on/off pattern. It takes commands as bytes from a serial receiver. In fixed mode it repeats one period and one duty code that were loaded over the byte link. In sweep mode a single start byte runs a schedule of periods. The outer loop moves to longer and longer periods. The inner loop walks the duty code upward from its lowest to its highest value. Each period and duty pair is repeated for a programmable number of whole periods.

The enable comes from a register, and period or duty changes are picked up only when a period ends. A new command therefore never produces a shortened pulse. The block's reset input is meant to be wired to the serial handshake line, so the host can return it to its default state. A busy flag is high while either mode is running.

The byte input is a valid/ready stream. The block never applies back-pressure: `rx_ready` stays high, and every byte presented with `rx_valid` is consumed on that clock edge.

Top module: `osc_sweep_gen`

## Requirements
- R1: While `rts_rst` is high, and after it is released, `grid_en` and `busy` are 0. The staged period is 40, the staged duty code is 3 and the staged dwell is 0.
- R2: `rx_ready` is always 1, and a byte is consumed on every rising edge where `rx_valid` is 1.
- R3: Byte 0x70 is followed by two period bytes, high byte first. A period value of 0 is stored as 1. Byte 0x64 is followed by one byte whose low 4 bits become the duty code. Byte 0x77 is followed by one byte that becomes the dwell.
- R4: Byte 0x66 received while idle starts fixed mode and sets `busy`. Period P begins in the cycle after the accepting edge. `grid_en` is 1 for the first H = floor(P*(duty+1)/16) cycles of each P-cycle period and 0 for the rest.
- R5: A period or duty loaded while fixed mode runs leaves the period in progress unchanged and applies from the next period onward.
- R6: Byte 0x73 ('s') received while idle starts the sweep and sets `busy`. Any byte that is not a command, such as 0x53, changes neither output.
- R7: The sweep uses periods 32, 48, 64 and 80 cycles, in that order. At each period the duty code runs 0, 1, …, 15. Each pair lasts dwell+1 whole periods, with its waveform as in R4. The first period begins in the cycle after the accepting edge.
- R8: After the last cycle of the final sweep period, `grid_en` and `busy` are both 0 and stay 0.
- R9: Bytes 0x73 and 0x66 received while `busy` is 1 have no effect on the running waveform.
- R10: Byte 0x78 stops either mode at once: `grid_en` and `busy` are 0 in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rts_rst | input | 1 | Synchronous active-high reset, driven from the serial handshake line |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_ready | output | 1 | Always 1; the block accepts every byte |
| grid_en | output | 1 | Registered enable for the oscillator grid |
| busy | output | 1 | High while fixed mode or the sweep is running |

## Verification
Every command takes effect on the edge that accepts its byte. Its effect on `grid_en` and `busy` is visible in the very next cycle, and cycle 0 of a new period is that cycle. A staged change appears only in the first cycle after the current period's last cycle. The bench drives each byte for exactly one cycle on a falling edge and samples on the following falling edge. It keeps its own count of the period position, so each sample of the enable is compared with the value the period, duty and dwell predict for that exact cycle.

// File: rtl/osc_sweep_pkg.sv
package osc_sweep_pkg;
  typedef enum logic [1:0] {MODE_IDLE, MODE_FIXED, MODE_SWEEP} mode_e;
  typedef enum logic [2:0] {DEC_CMD, DEC_PER_HI, DEC_PER_LO, DEC_DUTY, DEC_DWELL} dec_e;

  localparam logic [7:0] CH_PERIOD = 8'h70;
  localparam logic [7:0] CH_DUTY   = 8'h64;
  localparam logic [7:0] CH_DWELL  = 8'h77;
  localparam logic [7:0] CH_FIXED  = 8'h66;
  localparam logic [7:0] CH_SWEEP  = 8'h73;
  localparam logic [7:0] CH_STOP   = 8'h78;
endpackage

// File: rtl/osg_cmd_decoder.sv
module osg_cmd_decoder
  import osc_sweep_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int DUTY_W     = 4,
  parameter int DWELL_W    = 8,
  parameter int DEF_PERIOD = 40,
  parameter int DEF_DUTY   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         rx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  output logic [PER_W-1:0]   st_period,
  output logic [DUTY_W-1:0]  st_duty,
  output logic [DWELL_W-1:0] st_dwell,
  output logic               cmd_fixed,
  output logic               cmd_sweep,
  output logic               cmd_stop
);
  dec_e       st_q;
  logic [7:0] hi_q;
  logic [15:0] per_word;
  logic       in_cmd;

  assign rx_ready  = 1'b1;
  assign in_cmd    = rx_valid && (st_q == DEC_CMD);
  assign cmd_fixed = in_cmd && (rx_data == CH_FIXED);
  assign cmd_sweep = in_cmd && (rx_data == CH_SWEEP);
  assign cmd_stop  = in_cmd && (rx_data == CH_STOP);
  assign per_word  = {hi_q, rx_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= DEC_CMD;
      hi_q      <= '0;
      st_period <= PER_W'(DEF_PERIOD);
      st_duty   <= DUTY_W'(DEF_DUTY);
      st_dwell  <= '0;
    end else if (rx_valid) begin
      unique case (st_q)
        DEC_CMD: begin
          if (rx_data == CH_PERIOD)     st_q <= DEC_PER_HI;
          else if (rx_data == CH_DUTY)  st_q <= DEC_DUTY;
          else if (rx_data == CH_DWELL) st_q <= DEC_DWELL;
        end
        DEC_PER_HI: begin
          hi_q <= rx_data;
          st_q <= DEC_PER_LO;
        end
        DEC_PER_LO: begin
          st_period <= (per_word[PER_W-1:0] == '0) ? PER_W'(1) : per_word[PER_W-1:0];
          st_q      <= DEC_CMD;
        end
        DEC_DUTY: begin
          st_duty <= rx_data[DUTY_W-1:0];
          st_q    <= DEC_CMD;
        end
        DEC_DWELL: begin
          st_dwell <= rx_data[DWELL_W-1:0];
          st_q     <= DEC_CMD;
        end
        default: st_q <= DEC_CMD;
      endcase
    end
  end

  assert_period_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && st_q == DEC_CMD && rx_data == CH_PERIOD) |=> (st_q == DEC_PER_HI));
  assert_nonzero_period_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && st_q == DEC_PER_LO) |=> (st_period != '0));
endmodule

// File: rtl/osg_pwm_core.sv
module osg_pwm_core #(
  parameter int PER_W  = 16,
  parameter int DUTY_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              stop,
  input  logic [PER_W-1:0]  nxt_period,
  input  logic [DUTY_W-1:0] nxt_duty,
  output logic              en,
  output logic              wrap
);
  localparam int PROD_W = PER_W + DUTY_W + 1;

  logic [PER_W-1:0] cnt_q, per_q, cnt_inc;
  logic [PER_W:0]   high_q, nxt_high;
  logic [PROD_W-1:0] prod;
  logic             run_q, en_q;

  assign prod = {{(DUTY_W+1){1'b0}}, nxt_period}
              * {{PER_W{1'b0}}, ({1'b0, nxt_duty} + 1'b1)};
  assign nxt_high = prod[PROD_W-1:DUTY_W];
  assign cnt_inc  = cnt_q + 1'b1;
  assign wrap     = run_q && (cnt_q == per_q - 1'b1);
  assign en       = en_q;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      high_q <= '0;
      en_q   <= 1'b0;
    end else if (go || wrap) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      per_q  <= nxt_period;
      high_q <= nxt_high;
      en_q   <= (nxt_high != '0);
    end else if (run_q) begin
      cnt_q <= cnt_inc;
      en_q  <= ({1'b0, cnt_inc} < high_q);
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < per_q));
  assert_wrap_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (wrap && !stop) |=> (cnt_q == '0));
  assert_halt_low_R10: assert property (@(posedge clk) disable iff (rst)
    stop |=> !en);
endmodule

// File: rtl/osg_sweep_seq.sv
module osg_sweep_seq #(
  parameter int PER_W    = 16,
  parameter int DUTY_W   = 4,
  parameter int DWELL_W  = 8,
  parameter int P0       = 32,
  parameter int P_STEP   = 16,
  parameter int N_STEPS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               wrap,
  input  logic [DWELL_W-1:0] dwell_in,
  output logic [PER_W-1:0]   nxt_period,
  output logic [DUTY_W-1:0]  nxt_duty,
  output logic               last
);
  localparam int K_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

  logic [K_W-1:0]     k_q;
  logic [DUTY_W-1:0]  d_q;
  logic [DWELL_W-1:0] w_q, dwell_q;
  logic [PER_W-1:0]   per_q;
  logic               dwell_done, duty_top, k_last;

  assign dwell_done = (w_q == dwell_q);
  assign duty_top   = (d_q == '1);
  assign k_last     = (k_q == K_W'(N_STEPS - 1));
  assign last       = dwell_done && duty_top && k_last;

  always_comb begin
    nxt_period = per_q;
    nxt_duty   = d_q;
    if (start) begin
      nxt_period = PER_W'(P0);
      nxt_duty   = '0;
    end else if (wrap && dwell_done) begin
      if (duty_top) begin
        nxt_period = per_q + PER_W'(P_STEP);
        nxt_duty   = '0;
      end else begin
        nxt_duty = d_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q <= '0; d_q <= '0; w_q <= '0; dwell_q <= '0; per_q <= PER_W'(P0);
    end else if (start) begin
      k_q <= '0; d_q <= '0; w_q <= '0; dwell_q <= dwell_in; per_q <= PER_W'(P0);
    end else if (wrap) begin
      if (dwell_done) begin
        w_q <= '0;
        if (duty_top) begin
          d_q   <= '0;
          k_q   <= k_q + 1'b1;
          per_q <= per_q + PER_W'(P_STEP);
        end else begin
          d_q <= d_q + 1'b1;
        end
      end else begin
        w_q <= w_q + 1'b1;
      end
    end
  end

  assert_period_grows_R7: assert property (@(posedge clk) disable iff (rst)
    (wrap && !start && dwell_done && duty_top) |=> (per_q > $past(per_q) && d_q == '0));
  assert_dwell_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (wrap && !start && !dwell_done) |=> ($stable(d_q) && $stable(per_q)));
endmodule

// File: rtl/osc_sweep_gen.sv
module osc_sweep_gen
  import osc_sweep_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int DUTY_W     = 4,
  parameter int DWELL_W    = 8,
  parameter int DEF_PERIOD = 40,
  parameter int DEF_DUTY   = 3,
  parameter int SWEEP_P0   = 32,
  parameter int SWEEP_STEP = 16,
  parameter int SWEEP_N    = 4
) (
  input  logic       clk,
  input  logic       rts_rst,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       grid_en,
  output logic       busy
);
  mode_e               mode_q;
  logic [PER_W-1:0]    st_period, seq_period, pwm_period;
  logic [DUTY_W-1:0]   st_duty, seq_duty, pwm_duty;
  logic [DWELL_W-1:0]  st_dwell;
  logic                cmd_fixed, cmd_sweep, cmd_stop;
  logic                idle, go_fixed, go_sweep, pwm_wrap, sweep_wrap, seq_last;
  logic                use_seq, sweep_end, pwm_stop;

  osg_cmd_decoder #(
    .PER_W(PER_W), .DUTY_W(DUTY_W), .DWELL_W(DWELL_W),
    .DEF_PERIOD(DEF_PERIOD), .DEF_DUTY(DEF_DUTY)
  ) dec_i (
    .clk(clk), .rst(rts_rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .st_period(st_period), .st_duty(st_duty),
    .st_dwell(st_dwell), .cmd_fixed(cmd_fixed), .cmd_sweep(cmd_sweep),
    .cmd_stop(cmd_stop)
  );

  assign idle       = (mode_q == MODE_IDLE);
  assign go_fixed   = idle && cmd_fixed;
  assign go_sweep   = idle && cmd_sweep;
  assign sweep_wrap = pwm_wrap && (mode_q == MODE_SWEEP);
  assign sweep_end  = sweep_wrap && seq_last;
  assign pwm_stop   = cmd_stop || sweep_end;
  assign use_seq    = go_sweep || (mode_q == MODE_SWEEP);
  assign pwm_period = use_seq ? seq_period : st_period;
  assign pwm_duty   = use_seq ? seq_duty : st_duty;

  osg_sweep_seq #(
    .PER_W(PER_W), .DUTY_W(DUTY_W), .DWELL_W(DWELL_W),
    .P0(SWEEP_P0), .P_STEP(SWEEP_STEP), .N_STEPS(SWEEP_N)
  ) seq_i (
    .clk(clk), .rst(rts_rst), .start(go_sweep), .wrap(sweep_wrap),
    .dwell_in(st_dwell), .nxt_period(seq_period), .nxt_duty(seq_duty),
    .last(seq_last)
  );

  osg_pwm_core #(.PER_W(PER_W), .DUTY_W(DUTY_W)) pwm_i (
    .clk(clk), .rst(rts_rst), .go(go_fixed || go_sweep), .stop(pwm_stop),
    .nxt_period(pwm_period), .nxt_duty(pwm_duty), .en(grid_en), .wrap(pwm_wrap)
  );

  always_ff @(posedge clk) begin
    if (rts_rst || pwm_stop) mode_q <= MODE_IDLE;
    else if (go_fixed)       mode_q <= MODE_FIXED;
    else if (go_sweep)       mode_q <= MODE_SWEEP;
  end

  assign busy = !idle;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rts_rst)
    !busy |-> !grid_en);
  assert_sweep_end_R8: assert property (@(posedge clk) disable iff (rts_rst)
    sweep_end |=> (!busy && !grid_en));
  assert_stop_now_R10: assert property (@(posedge clk) disable iff (rts_rst)
    cmd_stop |=> !busy);
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rts_rst)
    (busy && !pwm_stop) |=> ($past(mode_q) == mode_q));
endmodule

// File: tb/osc_sweep_gen_tb_top.sv
`timescale 1ns/1ps
module osc_sweep_gen_tb_top;
  logic       clk = 1'b0;
  logic       rts_rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       rx_ready, grid_en, busy;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #2 clk = ~clk;

  osc_sweep_gen dut_i (
    .clk(clk), .rts_rst(rts_rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .grid_en(grid_en), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int hcalc(input int p, input int d);
    return (p * (d + 1)) / 16;
  endfunction

  // Called on a falling edge; returns on the next falling edge.
  task automatic send(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Checks period positions from..p-1; entered at the sample of position from.
  task automatic span(input int p, input int h, input int from, input string req,
                      output int bad);
    bad = 0;
    for (int c = from; c < p; c++) begin
      if (grid_en !== (c < h) || busy !== 1'b1) bad++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset;
    rts_rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(grid_en === 1'b0 && busy === 1'b0, "R1", "outputs during reset", {grid_en, busy}, 0);
    rts_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_defaults;
    int bad;
    do_reset();
    chk(grid_en === 1'b0 && busy === 1'b0, "R1", "outputs after reset", {grid_en, busy}, 0);
    chk(rx_ready === 1'b1, "R2", "ready after reset", rx_ready, 1);
    send(8'h66);
    span(40, 10, 0, "R1", bad);
    chk(bad == 0, "R1", "default 40/3 waveform mismatches", bad, 0);
    chk(rx_ready === 1'b1, "R2", "ready while running", rx_ready, 1);
    send(8'h78);
    chk(grid_en === 1'b0 && busy === 1'b0, "R10", "stop from fixed", {grid_en, busy}, 0);
  endtask

  task automatic t_non_command;
    bit seen = 0;
    send(8'h53);
    for (int i = 0; i < 6; i++) begin
      if (grid_en !== 1'b0 || busy !== 1'b0) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R6", "byte 0x53 idle effect", seen, 0);
  endtask

  task automatic t_fixed_and_boundary;
    int bad;
    send(8'h70); send(8'h00); send(8'h14);
    send(8'h64); send(8'h07);
    send(8'h66);
    span(20, 10, 0, "R4", bad);
    chk(bad == 0, "R4", "period 20 duty 7 first period", bad, 0);
    span(20, 10, 0, "R4", bad);
    chk(bad == 0, "R4", "period 20 duty 7 repeat", bad, 0);
    send(8'h64);
    send(8'hFF);
    span(20, 10, 2, "R5", bad);
    chk(bad == 0, "R5", "current period untouched by new duty", bad, 0);
    span(20, 20, 0, "R5", bad);
    chk(bad == 0, "R3", "duty from low nibble of 0xFF applied next period", bad, 0);
    send(8'h78);
    chk(grid_en === 1'b0 && busy === 1'b0, "R10", "stop", {grid_en, busy}, 0);
  endtask

  task automatic t_zero_period;
    bit seen = 0;
    send(8'h70); send(8'h00); send(8'h00);
    send(8'h64); send(8'h07);
    send(8'h66);
    for (int i = 0; i < 4; i++) begin
      if (grid_en !== 1'b0 || busy !== 1'b1) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R3", "period 0 as 1 with duty 7 stays low", seen, 0);
    send(8'h64);
    send(8'h0F);
    chk(grid_en === 1'b0, "R5", "old duty in running 1-cycle period", grid_en, 0);
    @(negedge clk);
    chk(grid_en === 1'b1, "R3", "period 1 duty 15 high", grid_en, 1);
    send(8'h78);
    chk(busy === 1'b0, "R10", "stop", busy, 0);
  endtask

  task automatic t_busy_ignore;
    send(8'h73);
    chk(grid_en === 1'b1 && busy === 1'b1, "R6", "sweep start cycle 0", {grid_en, busy}, 3);
    @(negedge clk);
    chk(grid_en === 1'b1, "R7", "period 32 duty 0 cycle 1", grid_en, 1);
    send(8'h73);
    chk(grid_en === 1'b0, "R9", "second 's' must not restart", grid_en, 0);
    send(8'h66);
    chk(grid_en === 1'b0 && busy === 1'b1, "R9", "'f' during sweep ignored", {grid_en, busy}, 1);
    send(8'h78);
    chk(grid_en === 1'b0 && busy === 1'b0, "R10", "stop sweep", {grid_en, busy}, 0);
  endtask

  task automatic t_full_sweep;
    int bad;
    int p;
    send(8'h77); send(8'h01);
    send(8'h73);
    for (int k = 0; k < 4; k++) begin
      p = 32 + 16 * k;
      for (int d = 0; d < 16; d++) begin
        int pair_bad = 0;
        for (int w = 0; w < 2; w++) begin
          span(p, hcalc(p, d), 0, "R7", bad);
          pair_bad += bad;
        end
        chk(pair_bad == 0, "R7", $sformatf("sweep pair period %0d duty %0d mismatches", p, d),
            pair_bad, 0);
      end
    end
    chk(grid_en === 1'b0 && busy === 1'b0, "R8", "after schedule", {grid_en, busy}, 0);
    repeat (5) @(negedge clk);
    chk(grid_en === 1'b0 && busy === 1'b0, "R8", "stays low", {grid_en, busy}, 0);
  endtask

  task automatic t_reset_mid_run;
    int bad;
    send(8'h70); send(8'h00); send(8'h14);
    send(8'h66);
    repeat (3) @(negedge clk);
    do_reset();
    send(8'h66);
    span(40, 10, 0, "R1", bad);
    chk(bad == 0, "R1", "defaults restored by reset", bad, 0);
    send(8'h78);
  endtask

  initial begin
    #(150000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_defaults();
    t_non_command();
    t_fixed_and_boundary();
    t_zero_period();
    t_busy_ignore();
    t_full_sweep();
    t_reset_mid_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule